// File: doc/BRIEF.md
# GF(2^m) Systolic A·B²+C Pipeline

This block evaluates Y = A·B² + C over the binary extension field GF(2^m). It uses a polynomial basis: bit i of every operand and of the result is the coefficient of x^i. The three operands enter side by side on parallel buses, and the result leaves on a parallel bus. Field arithmetic of this kind turns up in error-correcting decoders, where exponentiation, inversion and division are built as chains of such units.

The datapath is a linear systolic chain of M identical stages. Each stage consumes one bit of B, starting from the most significant bit. It multiplies the running partial result by x², reduces it by the field polynomial and conditionally adds A. The final stage also adds C. A, C, the bits of B not yet used and a valid flag travel along the chain beside their partial result. A new operand set can therefore enter on every clock, and each result appears exactly M cycles later. The field width and the low M bits of the irreducible polynomial are parameters. The leading x^M term is implied.

Top module: `gf_power_sum`

## Requirements
- R1: When valid_o is high, y_o equals A·B²+C computed in GF(2^M), reduced by the polynomial x^M + POLY. Bit i of each bus is the coefficient of x^i.
- R2: An operand set sampled with valid_i high at a rising clock edge produces valid_o high, with its result on y_o, exactly M rising edges later.
- R3: Operand sets presented on consecutive cycles each yield a correct result on consecutive cycles, in the same order.
- R4: valid_o is low in every cycle whose matching input cycle, M edges earlier, had valid_i low. Idle gaps in the input reappear at the output.
- R5: While rst_ni is low, valid_o is low. After reset is released, valid_o stays low until an input has had M edges to pass through the chain.
- R6: With B = 0, the result equals C for any A.
- R7: With A = 0, the result equals C for any B.
- R8: With B = 1, the result equals A XOR C.
- R9: When C equals A·B², the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand set on a_i, b_i, c_i is valid |
| a_i | input | M | Multiplicand A |
| b_i | input | M | Element B that gets squared |
| c_i | input | M | Addend C |
| valid_o | output | 1 | y_o carries a result |
| y_o | output | M | Result A·B²+C |

## Verification
A corrupted partial result, a stale A or C, or a misaligned B bit inside any stage changes y_o for the operand set that occupies that stage. The error shows on exactly one output word, M cycles after that set entered. The bench scores every output against a field model, so such faults surface at once in the word concerned. A broken valid path shows up as a result that arrives early or late, or that is missing or extra. The scoreboard flags this by comparing each arrival cycle with the issue cycle plus M.

// File: rtl/gf_ps_pkg.sv
package gf_ps_pkg;
  parameter int unsigned GF_M_DEFAULT = 8;
  // low bits of x^8 + x^4 + x^3 + x + 1
  parameter logic [31:0] GF_POLY_DEFAULT = 32'h1B;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/gf_ps_mulx2.sv
module gf_ps_mulx2 #(
  parameter int unsigned  M    = 8,
  parameter logic [M-1:0] POLY = '0
) (
  input  logic [M-1:0] p_i,
  output logic [M-1:0] p_o
);
  logic [M-1:0] once;

  always_comb begin
    once = {p_i[M-2:0], 1'b0} ^ (p_i[M-1] ? POLY : '0);
    p_o  = {once[M-2:0], 1'b0} ^ (once[M-1] ? POLY : '0);
  end
endmodule

// File: rtl/gf_ps_cell.sv
module gf_ps_cell #(
  parameter int unsigned  M    = 8,
  parameter logic [M-1:0] POLY = '0,
  parameter bit           LAST = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [M-1:0] p_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  input  logic [M-1:0] c_i,
  output logic         valid_o,
  output logic [M-1:0] p_o,
  output logic [M-1:0] a_o,
  output logic [M-1:0] b_o,
  output logic [M-1:0] c_o
);
  logic [M-1:0] p_sq;
  logic [M-1:0] p_next;

  gf_ps_mulx2 #(.M(M), .POLY(POLY)) u_mulx2 (
    .p_i (p_i),
    .p_o (p_sq)
  );

  // one AND level into one XOR level
  always_comb begin
    p_next = p_sq ^ (b_i[M-1] ? a_i : '0);
    if (LAST) p_next = p_next ^ c_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      p_o     <= '0;
      a_o     <= '0;
      b_o     <= '0;
      c_o     <= '0;
    end else begin
      valid_o <= valid_i;
      p_o     <= p_next;
      a_o     <= a_i;
      b_o     <= {b_i[M-2:0], 1'b0};
      c_o     <= c_i;
    end
  end

  generate
    if (LAST) begin : g_last_chk
      // zero partial and zero final bit must leave only C
      p_zero_b_tail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(p_i) == '0 && !$past(b_i[M-1])) |-> p_o == $past(c_i));
    end
  endgenerate
endmodule

// File: rtl/gf_power_sum.sv
module gf_power_sum
  import gf_ps_pkg::*;
#(
  parameter int unsigned  M    = GF_M_DEFAULT,
  parameter logic [M-1:0] POLY = GF_POLY_DEFAULT[M-1:0]
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  input  logic [M-1:0] c_i,
  output logic         valid_o,
  output logic [M-1:0] y_o
);
  localparam int unsigned CW = cnt_width(M + 1);

  logic         v_s [M+1];
  logic [M-1:0] p_s [M+1];
  logic [M-1:0] a_s [M+1];
  logic [M-1:0] b_s [M+1];
  logic [M-1:0] c_s [M+1];

  assign v_s[0] = valid_i;
  assign p_s[0] = '0;
  assign a_s[0] = a_i;
  assign b_s[0] = b_i;
  assign c_s[0] = c_i;

  for (genvar k = 0; k < M; k++) begin : g_stage
    gf_ps_cell #(.M(M), .POLY(POLY), .LAST(k == M - 1)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (v_s[k]),
      .p_i     (p_s[k]),
      .a_i     (a_s[k]),
      .b_i     (b_s[k]),
      .c_i     (c_s[k]),
      .valid_o (v_s[k+1]),
      .p_o     (p_s[k+1]),
      .a_o     (a_s[k+1]),
      .b_o     (b_s[k+1]),
      .c_o     (c_s[k+1])
    );
  end

  assign valid_o = v_s[M];
  assign y_o     = p_s[M];

  // checking state: items in flight, cycles since reset
  logic [CW-1:0] inflight_q;
  logic [CW-1:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inflight_q  <= '0;
      since_rst_q <= '0;
    end else begin
      inflight_q <= inflight_q + CW'(valid_i) - CW'(valid_o);
      if (since_rst_q < CW'(M)) since_rst_q <= since_rst_q + 1'b1;
    end
  end

  p_idle_after_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q < CW'(M)) |-> !valid_o);

  p_inflight_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CW'(M));

  p_out_needs_in_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> inflight_q != '0);

  p_reset_low_r5: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o);
endmodule

// File: tb/tb_gf_power_sum.sv
module tb_gf_power_sum;
  localparam int unsigned  M    = 8;
  localparam logic [M-1:0] POLY = 8'h1B;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_in = 1'b0;
  logic [M-1:0] a_in = '0, b_in = '0, c_in = '0;
  logic         valid_out;
  logic [M-1:0] y_out;

  int checks = 0, errors = 0;
  longint cyc = 0;

  typedef struct {
    logic [M-1:0] y;
    longint       due;
    string        req;
  } item_t;
  item_t q[$];

  gf_power_sum #(.M(M), .POLY(POLY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in),
    .a_i(a_in), .b_i(b_in), .c_i(c_in),
    .valid_o(valid_out), .y_o(y_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // LSB-first shift-and-add model
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M-1:0] acc = '0;
    logic [M-1:0] sh = x;
    for (int i = 0; i < M; i++) begin
      if (y[i]) acc ^= sh;
      sh = sh[M-1] ? ((sh << 1) ^ POLY) : (sh << 1);
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input logic [M-1:0] act,
                       input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic drive(input logic [M-1:0] a, input logic [M-1:0] b,
                       input logic [M-1:0] c, input string req);
    item_t it;
    @(negedge clk);
    valid_in = 1'b1; a_in = a; b_in = b; c_in = c;
    it.y = ref_mul(a, ref_mul(b, b)) ^ c;
    it.due = cyc + M;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_in = 1'b0; a_in = '1; b_in = '1; c_in = '1;
    end
  endtask

  // monitor: R2 timing, R4 gaps, R1 value
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        check(valid_out === 1'b1, {q[0].req, "/R2 valid"}, {{(M-1){1'b0}}, valid_out}, 1);
        check(y_out === q[0].y, q[0].req, y_out, q[0].y);
        void'(q.pop_front());
      end else begin
        check(valid_out === 1'b0, "R4 no spurious valid", {{(M-1){1'b0}}, valid_out}, 0);
      end
    end
  end

  initial begin
    logic [M-1:0] ra, rb;
    fork
      begin
        #1500000;
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check(valid_out === 1'b0, "R5 reset low", {{(M-1){1'b0}}, valid_out}, 0);
    rst_n = 1'b1;
    idle(M + 2); // R5: monitor sees no valid after release

    drive(8'h57, 8'h83, 8'h00, "R1 basic");
    drive(8'h00, 8'hA5, 8'h3C, "R7 zero A");
    drive(8'hC9, 8'h00, 8'h71, "R6 zero B");
    drive(8'h6D, 8'h01, 8'h92, "R8 unit B");
    drive(8'hFF, 8'hFF, 8'hFF, "R1 all ones");
    drive(8'h01, 8'h01, 8'h00, "R1 ones");
    drive(8'h80, 8'h80, 8'h80, "R1 top bits");
    ra = 8'h3B; rb = 8'hE4;
    drive(ra, rb, ref_mul(ra, ref_mul(rb, rb)), "R9 cancel");
    idle(3);
    drive(8'h12, 8'h34, 8'h56, "R4 after gap");
    idle(1);
    drive(8'hAB, 8'hCD, 8'hEF, "R4 single gap");
    for (int i = 0; i < 60; i++) begin
      ra = 8'($urandom); rb = 8'($urandom);
      drive(ra, rb, 8'($urandom), "R3 back-to-back");
    end
    idle(M + 4);
    check(q.size() == 0, "R2 all drained", 8'(q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule